// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves received Ethernet frames into system memory. Frames arrive as a byte stream marked with start and end flags. The block takes the next free receive descriptor from a ring in memory. A descriptor names a buffer and its size. The frame bytes are packed little-endian into 32-bit words and written into that buffer. When the frame is complete, the block writes a two-word status entry and then advances a produce index that only the hardware owns.

Software sets up the block through a small word-addressed register port. It programs the base address of the descriptor array, the base address of the status array, the ring size written as count minus one, and a consume index. Software advances the consume index after it has processed a slot. When the ring has no free slot, or receive is switched off, incoming frames are discarded whole. Error flags from the upstream receiver arrive with the last byte of a frame and are copied into the status entry. The block raises its own range error when a frame does not fit its buffer.

Top module: `rx_ring_writer`

## Requirements
- R1: For ring slot `idx`, the block reads the pointer word at `descBase + 8*idx` and then the control word at `descBase + 8*idx + 4`. Control bits 10:0 give the buffer size minus one. Control bit 31 has no effect on how data is stored.
- R2: Frame byte `k` goes to lane `k mod 4` (bits `8*(k mod 4)+7 : 8*(k mod 4)`) of the word at `pointer + 4*(k div 4)`. A final partial word is written with zeros in its unused lanes. A one-byte frame is stored as a single word.
- R3: Only the first `size` bytes of a frame longer than its buffer are written, and no word beyond the buffer is written. Status word 0 then has bit 26 set and length field `size-1`. A frame of exactly `size` bytes leaves bit 26 clear.
- R4: The status entry sits at `statBase + 8*idx`. Word 0 bits 10:0 hold the stored length minus one. Error inputs `inErr[0..4]` appear at bits 23, 24, 25, 27 and 28 respectively. Word 1 is written as zero.
- R5: Both status words are written after the last data word of the frame. The produce index (register 5) then steps by one modulo `ringLast+1` and wraps to 0 after `ringLast`.
- R6: When `(produce+1) mod (ringLast+1)` equals consume, the ring is full. A frame that arrives then is accepted and discarded with no memory write, and produce is unchanged. A later write to consume that frees a slot resumes reception.
- R7: Register 0 bit 0 enables receive. While it is 0, frames are discarded with no memory write. Register 1 bit 0 reads 1 while the block holds a descriptor or is writing a frame, and 0 when it is idle.
- R8: While a descriptor is held, bytes with the start flag low are discarded. The next frame that begins with a start byte still lands at the start of that slot's buffer.
- R9: Register map, by word address: 0 control, 1 state (read only), 2 descriptor base, 3 status base, 4 ring size minus one, 5 produce (read only), 6 consume. All of them read zero after reset.
- R10: The memory port never reads and writes in the same cycle. Read data is taken one cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | REG_AW | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| inValid | input | 1 | Stream byte valid |
| inReady | output | 1 | Stream byte accepted when high with inValid |
| inByte | input | 8 | Stream byte |
| inFirst | input | 1 | Byte is the first of a frame |
| inLast | input | 1 | Byte is the last of a frame |
| inErr | input | 5 | Receiver error flags, sampled with the last byte |
| memRdEn | output | 1 | Memory read request |
| memWrEn | output | 1 | Memory write request |
| memAddr | output | 32 | Memory byte address |
| memWrData | output | 32 | Memory write data |
| memRdData | input | 32 | Memory read data, one cycle after memRdEn |

## Verification
The hardest state to reach is the full ring: produce sits one slot behind consume while a frame is still arriving. The stimulus fills three slots of a four-slot ring, so the block stops at the idle boundary. It then sends a frame that must vanish without a single memory write, and only after that writes consume to reopen the ring. The produce index is then walked through its wrap to zero. The bench also checks that orphan bytes sent to an armed descriptor do not shift the next frame's placement.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

  localparam int WORD_W    = 32;
  localparam int LEN_W     = 11;
  localparam int ERR_N     = 5;
  localparam int RANGE_BIT = 26;

  // register word addresses
  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_STATE = 3'd1;
  localparam logic [2:0] REG_DBASE = 3'd2;
  localparam logic [2:0] REG_SBASE = 3'd3;
  localparam logic [2:0] REG_RLAST = 3'd4;
  localparam logic [2:0] REG_PROD  = 3'd5;
  localparam logic [2:0] REG_CONS  = 3'd6;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_PTR, S_RD_CTL, S_CAP_CTL, S_ARMED, S_RECV, S_FLUSH, S_ST0, S_ST1
  } ringState_e;

  typedef struct packed {
    logic rdPtr;
    logic rdCtl;
    logic capCtl;
    logic take;
    logic wrSt0;
    logic wrSt1;
  } ringStb_t;

  function automatic logic [WORD_W-1:0] errToStatus(input logic [ERR_N-1:0] e);
    logic [WORD_W-1:0] r;
    r = '0;
    r[23] = e[0];
    r[24] = e[1];
    r[25] = e[2];
    r[27] = e[3];
    r[28] = e[4];
    return r;
  endfunction

endpackage

// File: rtl/rxr_regs.sv
module rxr_regs
  import rxring_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              engineActive,
  input  logic [IDX_W-1:0]  prodIdx,
  output logic              rxOn,
  output logic [31:0]       descBase,
  output logic [31:0]       statBase,
  output logic [IDX_W-1:0]  ringLast,
  output logic [IDX_W-1:0]  consIdx
);

  localparam int PAD_W = 32 - IDX_W;

  logic [2:0] addrLo;
  assign addrLo = regAddr[2:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxOn     <= 1'b0;
      descBase <= '0;
      statBase <= '0;
      ringLast <= '0;
      consIdx  <= '0;
    end else if (regWrEn) begin
      case (addrLo)
        REG_CTRL:  rxOn     <= regWrData[0];
        REG_DBASE: descBase <= {regWrData[31:2], 2'b00};
        REG_SBASE: statBase <= {regWrData[31:3], 3'b000};
        REG_RLAST: ringLast <= regWrData[IDX_W-1:0];
        REG_CONS:  consIdx  <= regWrData[IDX_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    regRdData = '0;
    case (addrLo)
      REG_CTRL:  regRdData = {31'b0, rxOn};
      REG_STATE: regRdData = {31'b0, engineActive};
      REG_DBASE: regRdData = descBase;
      REG_SBASE: regRdData = statBase;
      REG_RLAST: regRdData = {{PAD_W{1'b0}}, ringLast};
      REG_PROD:  regRdData = {{PAD_W{1'b0}}, prodIdx};
      REG_CONS:  regRdData = {{PAD_W{1'b0}}, consIdx};
      default:   regRdData = '0;
    endcase
  end

endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
  import rxring_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxOn,
  input  logic [IDX_W-1:0] ringLast,
  input  logic [IDX_W-1:0] consIdx,
  input  logic             inValid,
  input  logic             inFirst,
  input  logic             inLast,
  output logic             inReady,
  output logic [IDX_W-1:0] prodIdx,
  output logic             engineActive,
  output ringStb_t         stb
);

  ringState_e state, stateNext;
  logic [IDX_W-1:0] prodNext;
  logic ringFull, canStart;

  assign prodNext = (prodIdx == ringLast) ? '0 : prodIdx + 1'b1;
  assign ringFull = (prodNext == consIdx);
  assign canStart = rxOn && !ringFull;

  always_comb begin
    stateNext = state;
    case (state)
      S_IDLE:    if (canStart) stateNext = S_RD_PTR;
      S_RD_PTR:  stateNext = S_RD_CTL;
      S_RD_CTL:  stateNext = S_CAP_CTL;
      S_CAP_CTL: stateNext = S_ARMED;
      S_ARMED: begin
        if (!rxOn)                   stateNext = S_IDLE;
        else if (inValid && inFirst) stateNext = inLast ? S_FLUSH : S_RECV;
      end
      S_RECV:  if (inValid && inLast) stateNext = S_FLUSH;
      S_FLUSH: stateNext = S_ST0;
      S_ST0:   stateNext = S_ST1;
      S_ST1:   stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      prodIdx <= '0;
    end else begin
      state <= stateNext;
      if (state == S_ST1) prodIdx <= prodNext;
    end
  end

  assign inReady = ((state == S_IDLE) && !canStart) || (state == S_ARMED) || (state == S_RECV);
  assign engineActive = (state != S_IDLE);

  always_comb begin
    stb        = '0;
    stb.rdPtr  = (state == S_RD_PTR);
    stb.rdCtl  = (state == S_RD_CTL);
    stb.capCtl = (state == S_CAP_CTL);
    stb.take   = inValid && (((state == S_ARMED) && rxOn && inFirst) || (state == S_RECV));
    stb.wrSt0  = (state == S_ST0);
    stb.wrSt1  = (state == S_ST1);
  end

  // R5: the produce index moves only when a status entry has just completed
  assert_prod_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (prodIdx != $past(prodIdx)) |-> ($past(state) == S_ST1));

  // R6: a descriptor fetch starts only if a slot was free and receive was on
  assert_no_fetch_full_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RD_PTR) |-> $past(canStart));

  // R7: no frame byte is taken while receive is off and no frame is in progress
  assert_off_no_take_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!rxOn && state != S_RECV) |-> !stb.take);

endmodule

// File: rtl/rxr_datapath.sv
module rxr_datapath
  import rxring_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ringStb_t         stb,
  input  logic [7:0]       inByte,
  input  logic             inLast,
  input  logic [ERR_N-1:0] inErr,
  input  logic [31:0]      descBase,
  input  logic [31:0]      statBase,
  input  logic [IDX_W-1:0] prodIdx,
  input  logic [31:0]      memRdData,
  output logic             memRdEn,
  output logic             memWrEn,
  output logic [31:0]      memAddr,
  output logic [31:0]      memWrData
);

  localparam int CNT_W  = LEN_W + 1;
  localparam int WIDX_W = CNT_W - 2;
  localparam int OFF_W  = 32 - IDX_W - 3;

  logic [31:0]        bufPtr;
  logic [LEN_W-1:0]   bufLimit;
  logic [CNT_W-1:0]   cnt;
  logic [31:0]        wordBuf;
  logic               bufHas;
  logic               pendValid;
  logic [31:0]        pendAddr;
  logic [31:0]        pendData;
  logic               ovf;
  logic [ERR_N-1:0]   errLatch;
  logic [LEN_W-1:0]   lenLatch;

  logic               store;
  logic [1:0]         lane;
  logic [31:0]        mergedWord;
  logic [WIDX_W-1:0]  wordIdx;
  logic               pendNow;
  logic [31:0]        slotOff;
  logic [31:0]        statInfo;

  assign store   = (cnt <= {1'b0, bufLimit});
  assign lane    = cnt[1:0];
  assign wordIdx = store ? cnt[CNT_W-1:2] : {1'b0, bufLimit[LEN_W-1:2]};
  assign pendNow = (store && lane == 2'd3) || (inLast && (store || bufHas));
  assign slotOff = {{OFF_W{1'b0}}, prodIdx, 3'b000};

  always_comb begin
    mergedWord = wordBuf;
    mergedWord[8*lane +: 8] = inByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufPtr    <= '0;
      bufLimit  <= '0;
      cnt       <= '0;
      wordBuf   <= '0;
      bufHas    <= 1'b0;
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendData  <= '0;
      ovf       <= 1'b0;
      errLatch  <= '0;
      lenLatch  <= '0;
    end else begin
      pendValid <= 1'b0;
      if (stb.rdCtl) bufPtr <= memRdData;
      if (stb.capCtl) begin
        bufLimit <= memRdData[LEN_W-1:0];
        cnt      <= '0;
        ovf      <= 1'b0;
        wordBuf  <= '0;
        bufHas   <= 1'b0;
      end
      if (stb.take) begin
        if (pendNow) begin
          pendValid <= 1'b1;
          pendAddr  <= bufPtr + {{(32-WIDX_W-2){1'b0}}, wordIdx, 2'b00};
          pendData  <= store ? mergedWord : wordBuf;
          wordBuf   <= '0;
          bufHas    <= 1'b0;
        end else if (store) begin
          wordBuf <= mergedWord;
          bufHas  <= 1'b1;
        end
        if (store) cnt <= cnt + 1'b1;
        else       ovf <= 1'b1;
        if (inLast) begin
          errLatch <= inErr;
          lenLatch <= store ? cnt[LEN_W-1:0] : bufLimit;
        end
      end
    end
  end

  always_comb begin
    statInfo = errToStatus(errLatch);
    statInfo[LEN_W-1:0] = lenLatch;
    statInfo[RANGE_BIT] = ovf;
  end

  always_comb begin
    memRdEn   = 1'b0;
    memWrEn   = 1'b0;
    memAddr   = '0;
    memWrData = '0;
    if (pendValid) begin
      memWrEn   = 1'b1;
      memAddr   = pendAddr;
      memWrData = pendData;
    end else if (stb.wrSt0) begin
      memWrEn   = 1'b1;
      memAddr   = statBase + slotOff;
      memWrData = statInfo;
    end else if (stb.wrSt1) begin
      memWrEn   = 1'b1;
      memAddr   = statBase + slotOff + 32'd4;
    end else if (stb.rdPtr) begin
      memRdEn = 1'b1;
      memAddr = descBase + slotOff;
    end else if (stb.rdCtl) begin
      memRdEn = 1'b1;
      memAddr = descBase + slotOff + 32'd4;
    end
  end

  // R3: every data write lands inside the descriptor's buffer
  assert_buf_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    pendValid |-> ((pendAddr - bufPtr) <= {{(32-LEN_W){1'b0}}, bufLimit}));

  // R3: the stored-byte count never runs past the buffer size
  assert_cnt_sat_R3: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= ({1'b0, bufLimit} + 1'b1));

  // R5: no data word is still waiting while the status entry is written
  assert_status_after_data_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrSt0 || stb.wrSt1) |-> !pendValid);

  // R10: reads and writes never share a cycle on the memory port
  assert_port_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn));

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxring_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              inValid,
  output logic              inReady,
  input  logic [7:0]        inByte,
  input  logic              inFirst,
  input  logic              inLast,
  input  logic [4:0]        inErr,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [31:0]       memAddr,
  output logic [31:0]       memWrData,
  input  logic [31:0]       memRdData
);

  logic             rxOn;
  logic [31:0]      descBase;
  logic [31:0]      statBase;
  logic [IDX_W-1:0] ringLast;
  logic [IDX_W-1:0] consIdx;
  logic [IDX_W-1:0] prodIdx;
  logic             engineActive;
  ringStb_t         stb;

  rxr_regs #(.IDX_W(IDX_W), .REG_AW(REG_AW)) regs_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .engineActive(engineActive),
    .prodIdx(prodIdx), .rxOn(rxOn), .descBase(descBase), .statBase(statBase),
    .ringLast(ringLast), .consIdx(consIdx)
  );

  rxr_ctrl #(.IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .rxOn(rxOn), .ringLast(ringLast), .consIdx(consIdx),
    .inValid(inValid), .inFirst(inFirst), .inLast(inLast), .inReady(inReady),
    .prodIdx(prodIdx), .engineActive(engineActive), .stb(stb)
  );

  rxr_datapath #(.IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .inByte(inByte), .inLast(inLast),
    .inErr(inErr), .descBase(descBase), .statBase(statBase), .prodIdx(prodIdx),
    .memRdData(memRdData), .memRdEn(memRdEn), .memWrEn(memWrEn),
    .memAddr(memAddr), .memWrData(memWrData)
  );

endmodule

// File: tb/rx_ring_writer_tb_top.sv
`timescale 1ns/1ps
module rx_ring_writer_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [7:0]  inByte = '0;
  logic        inFirst = 1'b0;
  logic        inLast = 1'b0;
  logic [4:0]  inErr = '0;
  logic        memRdEn, memWrEn;
  logic [31:0] memAddr, memWrData;
  logic [31:0] memRdData = '0;

  logic [31:0] mem [0:1023];
  int nChecks = 0;
  int nFails = 0;
  logic [31:0] expAddrQ[$];
  logic [31:0] expDataQ[$];
  string       expTagQ[$];
  logic [31:0] rv;

  localparam logic [31:0] DESC_BASE = 32'h100;
  localparam logic [31:0] STAT_BASE = 32'h200;
  localparam logic [31:0] BUF_BASE  = 32'h400;
  localparam int          BUF_SIZE  = 16;

  always #2.5 clk = ~clk;

  rx_ring_writer dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .inValid(inValid),
    .inReady(inReady), .inByte(inByte), .inFirst(inFirst), .inLast(inLast),
    .inErr(inErr), .memRdEn(memRdEn), .memWrEn(memWrEn), .memAddr(memAddr),
    .memWrData(memWrData), .memRdData(memRdData)
  );

  // memory model with one-cycle read latency
  always @(posedge clk) begin
    if (memWrEn) mem[memAddr[11:2]] <= memWrData;
    if (memRdEn) memRdData <= mem[memAddr[11:2]];
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every memory write is compared in order
  always @(negedge clk) begin
    if (rstN && memWrEn) begin
      if (expAddrQ.size() == 0) begin
        check(1'b0, "R6 unexpected write", memAddr, 32'hFFFF_FFFF);
      end else begin
        logic [31:0] ea, ed;
        string t;
        ea = expAddrQ.pop_front();
        ed = expDataQ.pop_front();
        t  = expTagQ.pop_front();
        check(memAddr == ea, {t, " address"}, memAddr, ea);
        check(memWrData == ed, {t, " data"}, memWrData, ed);
      end
    end
  end

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  function automatic logic [31:0] errBits(input logic [4:0] e);
    logic [31:0] r;
    r = 32'h0;
    if (e[0]) r = r | 32'h0080_0000;
    if (e[1]) r = r | 32'h0100_0000;
    if (e[2]) r = r | 32'h0200_0000;
    if (e[3]) r = r | 32'h0800_0000;
    if (e[4]) r = r | 32'h1000_0000;
    return r;
  endfunction

  // driver: pushes the expected writes, then sends the bytes
  task automatic sendFrame(input int n, input logic [7:0] seed, input logic [4:0] err,
                           input int slot, input string tag);
    if (slot >= 0) begin
      int m;
      logic [31:0] st;
      m = (n < BUF_SIZE) ? n : BUF_SIZE;
      for (int k = 0; k < (m + 3) / 4; k++) begin
        logic [31:0] w;
        w = 32'h0;
        for (int j = 0; j < 4; j++)
          if (4 * k + j < m) w[8*j +: 8] = seed + 8'(4 * k + j);
        expAddrQ.push_back(BUF_BASE + 32'(slot * 64 + 4 * k));
        expDataQ.push_back(w);
        expTagQ.push_back({tag, " data word"});
      end
      st = 32'(m - 1) | errBits(err);
      if (n > BUF_SIZE) st = st | 32'h0400_0000;
      expAddrQ.push_back(STAT_BASE + 32'(slot * 8));
      expDataQ.push_back(st);
      expTagQ.push_back({tag, " R4 status word0"});
      expAddrQ.push_back(STAT_BASE + 32'(slot * 8 + 4));
      expDataQ.push_back(32'h0);
      expTagQ.push_back({tag, " R5 status word1"});
    end
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      inValid = 1'b1; inByte = seed + 8'(i);
      inFirst = (i == 0); inLast = (i == n - 1); inErr = err;
      while (!inReady) @(negedge clk);
      @(negedge clk);
    end
    inValid = 1'b0; inFirst = 1'b0; inLast = 1'b0; inErr = '0;
    repeat (10) @(negedge clk);
  endtask

  task automatic sendOrphans(input int n);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      inValid = 1'b1; inByte = 8'hEE; inFirst = 1'b0; inLast = (i == n - 1);
      while (!inReady) @(negedge clk);
      @(negedge clk);
    end
    inValid = 1'b0; inLast = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hDEAD_BEEF;
    for (int s = 0; s < 4; s++) begin
      mem[(DESC_BASE >> 2) + 2 * s]     = BUF_BASE + 32'(s * 64);
      mem[(DESC_BASE >> 2) + 2 * s + 1] = (s == 3) ? 32'h8000_000F : 32'(BUF_SIZE - 1);
    end
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R9: reset values
    regRead(3'd0, rv); check(rv == 0, "R9 ctrl reset", rv, 0);
    regRead(3'd1, rv); check(rv == 0, "R9 state reset", rv, 0);
    regRead(3'd4, rv); check(rv == 0, "R9 ring size reset", rv, 0);
    regRead(3'd5, rv); check(rv == 0, "R9 produce reset", rv, 0);
    regRead(3'd6, rv); check(rv == 0, "R9 consume reset", rv, 0);

    regWrite(3'd2, DESC_BASE);
    regWrite(3'd3, STAT_BASE);
    regWrite(3'd4, 32'd3);
    regWrite(3'd6, 32'd0);
    regWrite(3'd0, 32'd1);
    repeat (8) @(negedge clk);
    regRead(3'd2, rv); check(rv == DESC_BASE, "R9 descriptor base readback", rv, DESC_BASE);
    regRead(3'd1, rv); check(rv == 1, "R7 active while armed", rv, 1);

    sendFrame(10, 8'h10, 5'b00000, 0, "R2 ten bytes");
    sendFrame(5, 8'h40, 5'b10101, 1, "R4 error flags");
    sendFrame(20, 8'h80, 5'b00000, 2, "R3 truncated");
    regRead(3'd5, rv); check(rv == 3, "R5 produce after three frames", rv, 3);
    regRead(3'd1, rv); check(rv == 0, "R6 idle when full", rv, 0);

    sendFrame(8, 8'hA0, 5'b00010, -1, "R6 dropped");
    regRead(3'd5, rv); check(rv == 3, "R6 produce held when full", rv, 3);

    regWrite(3'd6, 32'd3);
    repeat (8) @(negedge clk);
    sendFrame(4, 8'hC0, 5'b00000, 3, "R1 ctrl bit31 ignored");
    regRead(3'd5, rv); check(rv == 0, "R5 produce wraps", rv, 0);
    sendFrame(1, 8'h5A, 5'b01000, 0, "R2 single byte");
    regRead(3'd5, rv); check(rv == 1, "R5 produce step", rv, 1);

    regWrite(3'd0, 32'd0);
    repeat (4) @(negedge clk);
    regRead(3'd1, rv); check(rv == 0, "R7 idle when disabled", rv, 0);
    sendFrame(6, 8'h20, 5'b00000, -1, "R7 disabled drop");
    regRead(3'd5, rv); check(rv == 1, "R7 produce held when disabled", rv, 1);
    regWrite(3'd0, 32'd1);
    repeat (8) @(negedge clk);

    sendFrame(16, 8'h30, 5'b00000, 1, "R3 exact fit");
    regRead(3'd5, rv); check(rv == 2, "R5 produce after exact fit", rv, 2);

    regWrite(3'd6, 32'd0);
    repeat (10) @(negedge clk);
    sendOrphans(3);
    sendFrame(7, 8'h60, 5'b00001, 2, "R8 after orphans");
    regRead(3'd5, rv); check(rv == 3, "R8 produce after orphans", rv, 3);

    check(expAddrQ.size() == 0, "R5 all expected writes seen", 32'(expAddrQ.size()), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule